// File: doc/BRIEF.md
# Capture and Auto-Reload Timer

A 16-bit timer/counter paired with a 16-bit register that serves either as a capture latch or as a reload value. The block advances in machine-cycle steps, one step every twelve clocks. In timer function it adds one per step. In counter function it adds one for each high-to-low change seen on an external count pin, with that pin sampled once per step. A second external pin, the trigger pin, is sampled in the same way.

In capture mode the trigger pin's falling edge latches the running count. In auto-reload mode the same falling edge reloads the counter. When up/down counting is enabled, the trigger pin instead sets the count direction. An underflow is found by comparing the count with the reload value, and the external flag then acts as a 17th count bit. Software reads and writes the count, the reload/capture value and a control register through a single write port with a select field. The interrupt request is the OR of the two sticky flags.

Top module: `cap_reload_timer`

## Requirements
- R1: Control register fields: bit0 run, bit1 counter function (0 = timer), bit2 trigger enable, bit3 auto-reload mode (0 = capture), bit4 up/down enable, bit5 overflow flag, bit6 external flag, bit7 reads 0. After reset the count, the reload value, the control register and the interrupt request are all 0.
- R2: A step occurs on every 12th rising clock edge, the first on the 12th edge after reset is released. With run = 1 in timer function, the count increases by one at each step and is unchanged between steps. With run = 0, nothing changes except through software writes.
- R3: In counter function, the count pin is sampled at each step. A step that samples low, when the previous step sampled high, adds one. The sample register starts low after reset.
- R4: In capture mode, a counted step from 0xFFFF gives 0x0000 and sets the overflow flag.
- R5: In capture mode with trigger enable = 1, a falling edge of the trigger pin between two step samples copies the count held before that step into the reload register and sets the external flag. With trigger enable = 0, such an edge changes nothing.
- R6: In auto-reload mode with up/down enable = 0, a counted step from 0xFFFF loads the reload value and sets the overflow flag.
- R7: In auto-reload mode with up/down enable = 0 and trigger enable = 1, a falling edge of the trigger pin loads the reload value and sets the external flag.
- R8: When an overflow and a trigger edge fall in the same step, the overflow reload wins: the overflow flag is set and the external flag is left unchanged.
- R9: With auto-reload mode and up/down enable both set, the trigger pin level sampled at a step selects the direction: 1 counts up, 0 counts down. Counting up from 0xFFFF loads the reload value. Counting down at a count equal to the reload value loads 0xFFFF. Both cases set the overflow flag.
- R10: In up/down operation the external flag toggles on every overflow and every underflow. It does not drive the interrupt request, and trigger edges cause no reload.
- R11: The interrupt request is the overflow flag OR the external flag, with the external flag excluded during up/down operation. The flags stay set until software writes the control register.
- R12: Write select 0 writes the count, 1 writes the reload value, 2 writes control bits 6:0, and 3 writes nothing. A write takes effect at the next clock edge and overrides any hardware update of the same register at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_pin | input | 1 | External count pin (counter function) |
| ex_pin | input | 1 | Trigger pin / count direction |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for writes |
| wr_data | input | 16 | Write data |
| count_o | output | 16 | Current count |
| reload_o | output | 16 | Reload / capture register |
| ctrl_o | output | 8 | Control register and flags |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong prescaler phase would show on count_o within one step: the count would change on an edge that is not a multiple of twelve after reset. A stale pin sample would make a count, capture or reload appear one step early or late, visible at the next step edge. A wrong flag or direction state would appear on ctrl_o and irq_o at the overflow or underflow step itself, where the next count value also exposes a wrong reload source.

// File: rtl/crt_pkg.sv
package crt_pkg;
    localparam int TMR_W = 16;

    typedef enum logic [1:0] {
        SEL_CNT  = 2'd0,
        SEL_RLD  = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_NONE = 2'd3
    } sel_e;

    // bit 6 down to bit 0
    typedef struct packed {
        logic flag_ext;
        logic flag_ovf;
        logic updown;
        logic reload_mode;
        logic trig_en;
        logic counter_fn;
        logic run;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        logic [TMR_W-1:0] cnt;
        logic [TMR_W-1:0] rld;
        ctrl_t            ctrl;
    } state_t;
endpackage

// File: rtl/crt_prescaler.sv
module crt_prescaler #(
    parameter int DIV = 12
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [PW-1:0] ph_d, ph_q;

    always_comb begin
        tick = (ph_q == PW'(DIV - 1));
        ph_d = tick ? '0 : ph_q + PW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ph_q <= '0;
        else        ph_q <= ph_d;
    end

    generate
        if (DIV > 1) begin : g_spacing
            // R2
            step_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/crt_pin_sampler.sv
module crt_pin_sampler #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [N-1:0] pins,
    output logic [N-1:0] fall
);
    generate
        for (genvar i = 0; i < N; i++) begin : g_pin
            logic smp_d, smp_q;

            always_comb begin
                smp_d   = tick ? pins[i] : smp_q;
                fall[i] = tick & smp_q & ~pins[i];
            end

            always_ff @(posedge clk) begin
                if (!rst_n) smp_q <= 1'b0;
                else        smp_q <= smp_d;
            end

            // R3
            fall_on_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
                fall[i] |-> tick);
        end
    endgenerate
endmodule

// File: rtl/cap_reload_timer.sv
module cap_reload_timer
    import crt_pkg::*;
#(
    parameter int CLKS_PER_STEP = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_pin,
    input  logic              ex_pin,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [TMR_W-1:0]  wr_data,
    output logic [TMR_W-1:0]  count_o,
    output logic [TMR_W-1:0]  reload_o,
    output logic [CTRL_W:0]   ctrl_o,
    output logic              irq_o
);
    localparam logic [TMR_W-1:0] MAXV = '1;

    logic       tick;
    logic [1:0] falls;
    state_t     s_d, s_q;
    logic       inc, trig, ud_op;
    logic       wr_cnt, wr_rld, wr_ctl;

    crt_prescaler #(.DIV(CLKS_PER_STEP)) i_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    crt_pin_sampler #(.N(2)) i_smp (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .pins  ({ex_pin, cnt_pin}),
        .fall  (falls)
    );

    always_comb begin
        wr_cnt = wr_en && (wr_sel == SEL_CNT);
        wr_rld = wr_en && (wr_sel == SEL_RLD);
        wr_ctl = wr_en && (wr_sel == SEL_CTRL);
        ud_op  = s_q.ctrl.reload_mode && s_q.ctrl.updown;
        inc    = s_q.ctrl.counter_fn ? falls[0] : tick;
        trig   = falls[1] && s_q.ctrl.trig_en;

        s_d = s_q;
        if (tick && s_q.ctrl.run) begin
            if (!s_q.ctrl.reload_mode) begin
                if (inc) begin
                    s_d.cnt = s_q.cnt + TMR_W'(1);
                    if (s_q.cnt == MAXV) s_d.ctrl.flag_ovf = 1'b1;
                end
                if (trig) begin
                    s_d.rld           = s_q.cnt;
                    s_d.ctrl.flag_ext = 1'b1;
                end
            end else if (!s_q.ctrl.updown) begin
                if (inc && s_q.cnt == MAXV) begin
                    s_d.cnt           = s_q.rld;
                    s_d.ctrl.flag_ovf = 1'b1;
                end else if (trig) begin
                    s_d.cnt           = s_q.rld;
                    s_d.ctrl.flag_ext = 1'b1;
                end else if (inc) begin
                    s_d.cnt = s_q.cnt + TMR_W'(1);
                end
            end else if (inc) begin
                if (ex_pin) begin
                    if (s_q.cnt == MAXV) begin
                        s_d.cnt           = s_q.rld;
                        s_d.ctrl.flag_ovf = 1'b1;
                        s_d.ctrl.flag_ext = ~s_q.ctrl.flag_ext;
                    end else begin
                        s_d.cnt = s_q.cnt + TMR_W'(1);
                    end
                end else begin
                    if (s_q.cnt == s_q.rld) begin
                        s_d.cnt           = MAXV;
                        s_d.ctrl.flag_ovf = 1'b1;
                        s_d.ctrl.flag_ext = ~s_q.ctrl.flag_ext;
                    end else begin
                        s_d.cnt = s_q.cnt - TMR_W'(1);
                    end
                end
            end
        end

        if (wr_cnt) s_d.cnt  = wr_data;
        if (wr_rld) s_d.rld  = wr_data;
        if (wr_ctl) s_d.ctrl = ctrl_t'(wr_data[CTRL_W-1:0]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign count_o  = s_q.cnt;
    assign reload_o = s_q.rld;
    assign ctrl_o   = {1'b0, s_q.ctrl};
    assign irq_o    = s_q.ctrl.flag_ovf | (s_q.ctrl.flag_ext & ~ud_op);

    // R2
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.ctrl.run && !wr_en) |=> $stable(count_o) && $stable(reload_o) && $stable(ctrl_o));

    // R11
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ctrl.flag_ovf && !wr_ctl) |=> s_q.ctrl.flag_ovf);

    // R4
    capture_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.ctrl.reload_mode && !wr_cnt && !wr_ctl) |=>
            (count_o == $past(count_o)) || (count_o == $past(count_o) + TMR_W'(1)));

    // R10
    ud_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ud_op && !wr_en && !s_q.ctrl.flag_ovf) |=> ($stable(s_q.ctrl.flag_ext) || s_q.ctrl.flag_ovf));

    // R10
    ud_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ud_op && !s_q.ctrl.flag_ovf) |-> !irq_o);
endmodule

// File: tb/test_cap_reload_timer.sv
`timescale 1ns/1ps
module test_cap_reload_timer;
    localparam int DIV = 12;
    localparam logic [7:0] C_RUN = 8'h01, C_CNT = 8'h02, C_TEN = 8'h04,
                           C_RLD = 8'h08, C_UD = 8'h10, C_OVF = 8'h20, C_EXF = 8'h40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_pin = 1'b0, ex_pin = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic [15:0] count_o, reload_o;
    logic [7:0]  ctrl_o;
    logic        irq_o;

    int n_tests = 0;
    int n_fail  = 0;
    int ecnt    = 0;

    always #2 clk = ~clk;

    always @(posedge clk) if (rst_n) ecnt <= ecnt + 1;

    cap_reload_timer i_cap_reload_timer (
        .clk(clk), .rst_n(rst_n), .cnt_pin(cnt_pin), .ex_pin(ex_pin),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .count_o(count_o), .reload_o(reload_o), .ctrl_o(ctrl_o), .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_tick();
        do begin
            @(posedge clk);
            #1;
        end while (ecnt % DIV != 0);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] c1, exp_c;
        logic        prev;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 count", count_o, 0);
        check("R1 reload", reload_o, 0);
        check("R1 ctrl", ctrl_o, 0);
        check("R1 irq", irq_o, 0);

        // R2 / R4 timer function, wrap
        wait_tick();
        wr(0, 16'hFFFD);
        wr(2, C_RUN);
        wait_tick(); check("R2 step", count_o, 16'hFFFE);
        wait_tick(); check("R2 step", count_o, 16'hFFFF);
        wait_tick(); check("R4 wrap", count_o, 16'h0000);
        check("R4 ovf flag", ctrl_o, C_RUN | C_OVF);
        check("R11 irq", irq_o, 1);
        wait_tick(); check("R11 flag held", ctrl_o, C_RUN | C_OVF);
        c1 = count_o;
        repeat (11) @(posedge clk);
        #1; check("R2 no change mid-step", count_o, c1);
        @(posedge clk); #1; check("R2 twelfth edge", count_o, c1 + 16'd1);
        wr(2, C_RUN);
        check("R11 sw clear", irq_o, 0);
        check("R11 ctrl clear", ctrl_o, C_RUN);
        wr(2, 0);
        c1 = count_o;
        repeat (3) wait_tick();
        check("R2 run off", count_o, c1);

        // R3 counter function sweep
        wait_tick();
        wr(2, C_RUN | C_CNT);
        wr(0, 0);
        exp_c = 0;
        prev  = 1'b0;
        for (int p = 0; p < 64; p++) begin
            for (int b = 0; b < 6; b++) begin
                cnt_pin = p[b];
                wait_tick();
                if (prev && !p[b]) exp_c = exp_c + 16'd1;
                prev = p[b];
            end
            check("R3 edge count", count_o, exp_c);
        end
        cnt_pin = 1'b0;
        wait_tick();

        // R5 capture
        wait_tick();
        wr(2, C_RUN | C_TEN);
        wr(1, 0);
        wr(0, 16'h0100);
        ex_pin = 1'b1;
        wait_tick();
        c1 = count_o;
        ex_pin = 1'b0;
        wait_tick();
        check("R5 captured", reload_o, c1);
        check("R5 count moves on", count_o, c1 + 16'd1);
        check("R5 ext flag", ctrl_o, C_RUN | C_TEN | C_EXF);
        check("R11 irq ext", irq_o, 1);
        wait_tick();
        wr(2, C_RUN);
        wr(1, 16'h1234);
        ex_pin = 1'b1; wait_tick();
        ex_pin = 1'b0; wait_tick();
        check("R5 disabled reload", reload_o, 16'h1234);
        check("R5 disabled flags", ctrl_o, C_RUN);

        // R6 auto-reload overflow
        wait_tick();
        wr(1, 16'hFFF0);
        wr(0, 16'hFFFE);
        wr(2, C_RUN | C_RLD);
        wait_tick(); check("R6 up", count_o, 16'hFFFF);
        wait_tick(); check("R6 reload", count_o, 16'hFFF0);
        check("R6 ovf", ctrl_o, C_RUN | C_RLD | C_OVF);

        // R7 triggered reload
        wait_tick();
        wr(2, C_RUN | C_RLD | C_TEN);
        wr(0, 16'h0010);
        wr(1, 16'hABCD);
        ex_pin = 1'b1; wait_tick();
        check("R7 before", count_o, 16'h0011);
        ex_pin = 1'b0; wait_tick();
        check("R7 reload", count_o, 16'hABCD);
        check("R7 flags", ctrl_o, C_RUN | C_RLD | C_TEN | C_EXF);

        // R8 overflow vs trigger
        wait_tick();
        wr(2, C_RUN | C_RLD | C_TEN);
        wr(0, 16'hFFFE);
        wr(1, 16'h2222);
        ex_pin = 1'b1; wait_tick();
        ex_pin = 1'b0; wait_tick();
        check("R8 count", count_o, 16'h2222);
        check("R8 flags", ctrl_o, C_RUN | C_RLD | C_TEN | C_OVF);

        // R9 / R10 up/down
        wait_tick();
        wr(2, C_RUN | C_RLD | C_UD);
        wr(1, 16'h0005);
        wr(0, 16'h0007);
        wait_tick(); check("R9 down", count_o, 16'h0006);
        wait_tick(); check("R9 down", count_o, 16'h0005);
        wait_tick(); check("R9 underflow", count_o, 16'hFFFF);
        check("R10 toggle", ctrl_o, C_RUN | C_RLD | C_UD | C_OVF | C_EXF);
        wr(2, C_RUN | C_RLD | C_UD | C_EXF);
        check("R10 no irq", irq_o, 0);
        wait_tick(); check("R9 down wrap", count_o, 16'hFFFE);
        ex_pin = 1'b1;
        wait_tick(); check("R9 up", count_o, 16'hFFFF);
        wait_tick(); check("R9 overflow", count_o, 16'h0005);
        check("R10 toggle back", ctrl_o, C_RUN | C_RLD | C_UD | C_OVF);
        wait_tick();
        wr(2, C_RUN | C_RLD | C_UD | C_TEN);
        wr(0, 16'h0100);
        wait_tick(); check("R9 up", count_o, 16'h0101);
        ex_pin = 1'b0;
        wait_tick(); check("R10 no trigger", count_o, 16'h0100);
        check("R10 no flag", ctrl_o, C_RUN | C_RLD | C_UD | C_TEN);

        // R12 writes
        wait_tick();
        wr(2, C_RUN);
        wr(0, 16'h0040);
        wait_tick();
        repeat (11) @(posedge clk);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'd0; wr_data = 16'h0500;
        @(posedge clk);
        #1; wr_en = 1'b0;
        check("R12 write wins", count_o, 16'h0500);
        wait_tick(); check("R12 then counts", count_o, 16'h0501);
        wr(2, 0);
        wr(1, 16'h3C3C);
        check("R12 reload write", reload_o, 16'h3C3C);
        c1 = count_o;
        wr(3, 16'hFFFF);
        check("R12 sel3 count", count_o, c1);
        check("R12 sel3 reload", reload_o, 16'h3C3C);
        check("R12 sel3 ctrl", ctrl_o, 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule